// File: doc/BRIEF.md
# Serial Flash Status-Register Front End

This block is the serial-side command decoder of a NOR flash device for the instructions that touch the status register. A host drives an active-low select, a serial clock and a data-in line. The block shifts in an 8-bit opcode and acts on four of them. Two opcodes set or clear the write-enable latch. The other two read one of two status bytes, which are streamed out on the data-out line and repeated for as long as the select stays low.

All serial inputs are resynchronised into the device's core clock, so the block runs in a single clock domain. The array controller supplies the busy flag and the protection, security and quad-mode bits. It also gives a one-cycle pulse when a status write, program or erase cycle finishes, and that pulse clears the latch. The latch is exported to the array controller so that a write can be qualified by it. Status reads are never refused, so a host can poll the busy flag while a program or erase cycle runs.

Top module: `flash_status_slave`

## Requirements
- R1: After reset the write-enable latch (`wel_o`) reads 0 and `spi_do_oe_o` is 0.
- R2: The opcode is taken from `spi_di_i` on rising serial-clock edges, MSB first. It is exactly 8 bits. The serial clock may idle low or high while the select is high (mode 0 and mode 3).
- R3: Opcode 0x05 returns status byte 1, laid out from bit 7 down to bit 0 as {srp0, sec, tb, bp[2], bp[1], bp[0], wel, busy}. Each bit is driven on `spi_do_o` after a falling serial-clock edge, MSB first.
- R4: Opcode 0x35 returns status byte 2 as {6'b000000, qe, srp1}.
- R5: While the select stays low after a read opcode, the selected status byte is sent again and again without limit.
- R6: The status value is captured at the first falling edge of each output byte. A change of `arr_busy_i` in the middle of a byte shows only from the next byte on. A read is answered while `arr_busy_i` is 1.
- R7: Opcode 0x06 sets the latch and opcode 0x04 clears it. Each takes effect when the select rises after all 8 opcode bits have been received.
- R8: A pulse on `arr_done_i` clears the latch on the next clock edge.
- R9: A transaction whose select rises before 8 opcode bits have been received changes nothing.
- R10: Any other opcode is ignored, and `spi_do_oe_o` stays 0 for the rest of that transaction.
- R11: `spi_do_oe_o` is 0 during the opcode phase and while the select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_sck_i | input | 1 | Serial clock from the host |
| spi_cs_ni | input | 1 | Chip select, active low |
| spi_di_i | input | 1 | Serial data in |
| spi_do_o | output | 1 | Serial data out |
| spi_do_oe_o | output | 1 | Output enable for the data-out pad; 0 means high impedance |
| arr_busy_i | input | 1 | Array cycle in progress |
| arr_bp_i | input | 3 | Block-protect bits |
| arr_tb_i | input | 1 | Top/bottom protect select |
| arr_sec_i | input | 1 | Sector/block protect granularity |
| arr_srp0_i | input | 1 | Status-protect bit 0 |
| arr_srp1_i | input | 1 | Status-protect bit 1 |
| arr_qe_i | input | 1 | Quad enable |
| arr_done_i | input | 1 | One-cycle pulse when a status write, program or erase cycle finishes |
| wel_o | output | 1 | Write-enable latch |

## Verification
Each serial pin edge takes two synchroniser stages plus one register, so a new data-out bit is valid three core clocks after a falling serial-clock edge. A latch change is likewise visible three core clocks after the select rises. The done pulse clears the latch one clock after it is seen. The bench holds every serial-clock level for eight core clocks and samples only just before the next edge, well past the three-clock delay. It waits a further eight clocks after the select rises before looking at `wel_o`, and checks the done-pulse effect two clocks after the pulse.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int OP_W = 8;
  localparam int ST_W = 8;

  localparam logic [OP_W-1:0] OP_WREN  = 8'h06;
  localparam logic [OP_W-1:0] OP_WRDI  = 8'h04;
  localparam logic [OP_W-1:0] OP_RDST1 = 8'h05;
  localparam logic [OP_W-1:0] OP_RDST2 = 8'h35;

  typedef struct packed {
    logic       srp0;
    logic       sec;
    logic       tb;
    logic [2:0] bp;
    logic       wel;
    logic       busy;
  } st1_t;

  function automatic logic [ST_W-1:0] st2_pack(input logic qe, input logic srp1);
    return {6'b000000, qe, srp1};
  endfunction
endpackage

// File: rtl/fss_sync.sv
module fss_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES*W-1:0] chain_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) chain_q <= RST_VAL;
      else         chain_q <= d_i;
  end else begin : g_many
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
      else         chain_q <= {chain_q[(STAGES-1)*W-1:0], d_i};
  end

  assign q_o = chain_q[STAGES*W-1 -: W];
endmodule

// File: rtl/fss_cmd_rx.sv
module fss_cmd_rx
  import fss_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            rise_i,
  input  logic            di_i,
  output logic [OP_W-1:0] op_o,
  output logic            vld_o
);
  localparam int CNT_W = $clog2(OP_W);

  logic [CNT_W-1:0] cnt_q;
  logic [OP_W-1:0]  sh_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
      vld_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else if (rise_i && !vld_q) begin
      sh_q  <= {sh_q[OP_W-2:0], di_i};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(OP_W-1)) vld_q <= 1'b1;
    end
  end

  assign op_o  = sh_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/fss_tx.sv
module fss_tx #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         fall_i,
  input  logic [W-1:0] byte_i,
  output logic         do_o,
  output logic         oe_o
);
  localparam int CNT_W = $clog2(W);

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     sh_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
      act_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (fall_i) begin
      act_q <= 1'b1;
      // capture a fresh status value at every byte boundary
      sh_q  <= (cnt_q == '0) ? byte_i : {sh_q[W-2:0], 1'b0};
      cnt_q <= (cnt_q == CNT_W'(W-1)) ? '0 : cnt_q + 1'b1;
    end
  end

  assign oe_o = act_q & en_i;
  assign do_o = oe_o & sh_q[W-1];
endmodule

// File: rtl/flash_status_slave.sv
module flash_status_slave
  import fss_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       spi_sck_i,
  input  logic       spi_cs_ni,
  input  logic       spi_di_i,
  output logic       spi_do_o,
  output logic       spi_do_oe_o,
  input  logic       arr_busy_i,
  input  logic [2:0] arr_bp_i,
  input  logic       arr_tb_i,
  input  logic       arr_sec_i,
  input  logic       arr_srp0_i,
  input  logic       arr_srp1_i,
  input  logic       arr_qe_i,
  input  logic       arr_done_i,
  output logic       wel_o
);
  logic cs_s, sck_s, di_s;
  logic cs_q, sck_q;
  logic cs_fall, cs_rise, sck_rise, sck_fall;
  logic [OP_W-1:0] op;
  logic            op_vld;
  logic            rd_op, tx_en;
  logic [ST_W-1:0] st_byte;
  logic            wel_q;
  st1_t            st1;

  fss_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({spi_cs_ni, spi_sck_i, spi_di_i}),
    .q_o    ({cs_s, sck_s, di_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
    end
  end

  assign cs_fall  =  cs_q & ~cs_s;
  assign cs_rise  = ~cs_q &  cs_s;
  assign sck_rise =  sck_s & ~sck_q & ~cs_s;
  assign sck_fall = ~sck_s &  sck_q & ~cs_s;

  fss_cmd_rx u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cs_fall),
    .rise_i  (sck_rise),
    .di_i    (di_s),
    .op_o    (op),
    .vld_o   (op_vld)
  );

  assign rd_op = op_vld && (op == OP_RDST1 || op == OP_RDST2);
  assign tx_en = ~cs_s & rd_op;

  always_comb begin
    st1 = '{srp0: arr_srp0_i, sec: arr_sec_i, tb: arr_tb_i, bp: arr_bp_i,
            wel: wel_q, busy: arr_busy_i};
    st_byte = (op == OP_RDST2) ? st2_pack(arr_qe_i, arr_srp1_i) : st1;
  end

  fss_tx #(.W(ST_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tx_en),
    .fall_i (sck_fall),
    .byte_i (st_byte),
    .do_o   (spi_do_o),
    .oe_o   (spi_do_oe_o)
  );

  // completion of an array cycle outranks a write-enable opcode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          wel_q <= 1'b0;
    else if (arr_done_i)                  wel_q <= 1'b0;
    else if (cs_rise && op_vld) begin
      if (op == OP_WREN)                  wel_q <= 1'b1;
      else if (op == OP_WRDI)             wel_q <= 1'b0;
    end
  end

  assign wel_o = wel_q;
endmodule

// File: rtl/fss_chk.sv
module fss_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_s_i,
  input logic cs_q_i,
  input logic do_oe_i,
  input logic wel_i,
  input logic done_i
);
  // R11
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s_i && $past(cs_s_i)) |-> !do_oe_i);

  // R10
  oe_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(do_oe_i) |-> !cs_s_i);

  // R8
  done_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !wel_i);

  // R7
  wel_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_i) |-> ($past(cs_s_i) && !$past(cs_q_i) && !$past(done_i)));

  // R7
  wel_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wel_i) |-> ($past(done_i) || ($past(cs_s_i) && !$past(cs_q_i))));

  // R1
  always_comb
    if (!rst_ni) rst_state_chk: assert (!do_oe_i);
endmodule

bind flash_status_slave fss_chk u_fss_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_s_i  (cs_s),
  .cs_q_i  (cs_q),
  .do_oe_i (spi_do_oe_o),
  .wel_i   (wel_o),
  .done_i  (arr_done_i)
);

// File: tb/flash_status_slave_tb_top.sv
module flash_status_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, oe, wel;
  logic busy = 1'b0, tb = 1'b0, sec = 1'b0, srp0 = 1'b0, srp1 = 1'b0, qe = 1'b0, done = 1'b0;
  logic [2:0] bp = 3'b000;

  int n_checks = 0, n_errors = 0;
  bit finished = 1'b0;
  bit wel_m = 1'b0;

  logic [7:0] exp_q[$];
  string      req_q[$];
  logic [7:0] got_byte;
  event       byte_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .spi_sck_i(sck), .spi_cs_ni(cs_n), .spi_di_i(mosi),
    .spi_do_o(miso), .spi_do_oe_o(oe),
    .arr_busy_i(busy), .arr_bp_i(bp), .arr_tb_i(tb), .arr_sec_i(sec),
    .arr_srp0_i(srp0), .arr_srp1_i(srp1), .arr_qe_i(qe),
    .arr_done_i(done), .wel_o(wel)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] op);
    if (op == 8'h35) return {6'b000000, qe, srp1};
    return {srp0, sec, tb, bp, wel_m, busy};
  endfunction

  // monitor: pops the expected byte as each received byte completes
  initial forever begin
    @(byte_ev);
    if (exp_q.size() == 0) check(1'b0, "unexpected byte", got_byte, 8'h00);
    else begin
      logic [7:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check(got_byte == e, r, got_byte, e);
    end
  end

  // driver: one select-low transaction
  task automatic xfer(input logic [7:0] op, input int op_bits, input int nbytes,
                      input bit cpol, input bit rd, input bit flip, input string req);
    bit oe_op, oe_bad;
    logic [7:0] got;
    oe_op = 1'b0;
    oe_bad = 1'b0;
    sck = cpol;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < op_bits; i++) begin
      sck = 1'b0;
      mosi = op[7-i];
      wait_clk(HALF);
      if (oe) oe_op = 1'b1;
      sck = 1'b1;
      wait_clk(HALF);
      if (oe) oe_op = 1'b1;
    end
    check(!oe_op, "R11 oe during opcode", {7'b0, oe_op}, 8'h00);
    for (int b = 0; b < nbytes; b++) begin
      if (rd) begin
        exp_q.push_back(exp_byte(op));
        req_q.push_back(req);
      end
      got = '0;
      for (int i = 0; i < 8; i++) begin
        sck = 1'b0;
        wait_clk(HALF);
        got = {got[6:0], miso};
        if (oe != rd) oe_bad = 1'b1;
        if (flip && b == 0 && i == 3) busy = 1'b1;
        sck = 1'b1;
        wait_clk(HALF);
      end
      if (rd) begin
        got_byte = got;
        ->byte_ev;
      end
    end
    if (nbytes > 0)
      check(!oe_bad, rd ? "R3 oe during read" : "R10 oe for ignored opcode", {7'b0, oe_bad}, 8'h00);
    if (!cpol) begin
      sck = 1'b0;
      wait_clk(HALF);
    end
    cs_n = 1'b1;
    wait_clk(HALF);
    check(!oe, "R11 oe after select high", {7'b0, oe}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", 8'h00, 8'h01);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    check(!oe, "R1 oe at reset", {7'b0, oe}, 8'h00);
    rst_n = 1'b1;
    wait_clk(5);
    check(wel == 1'b0, "R1 wel after reset", {7'b0, wel}, 8'h00);
    check(!oe, "R1 oe after reset", {7'b0, oe}, 8'h00);

    srp0 = 1'b1; tb = 1'b1; bp = 3'b101; srp1 = 1'b1;
    xfer(8'h05, 8, 1, 1'b0, 1'b1, 1'b0, "R3 status1 mode 0");

    xfer(8'h06, 8, 0, 1'b0, 1'b0, 1'b0, "R7 write enable");
    wel_m = 1'b1;
    check(wel == 1'b1, "R7 wel set", {7'b0, wel}, 8'h01);
    xfer(8'h05, 8, 2, 1'b1, 1'b1, 1'b0, "R2 R5 status1 mode 3 repeated");

    busy = 1'b1;
    xfer(8'h05, 8, 1, 1'b0, 1'b1, 1'b0, "R6 read while busy");
    busy = 1'b0;
    xfer(8'h05, 8, 3, 1'b0, 1'b1, 1'b1, "R6 R5 busy change at byte boundary");
    busy = 1'b0;

    qe = 1'b1; sec = 1'b1;
    xfer(8'h35, 8, 2, 1'b1, 1'b1, 1'b0, "R4 status2 mode 3");
    qe = 1'b0; srp1 = 1'b0;
    xfer(8'h35, 8, 1, 1'b0, 1'b1, 1'b0, "R4 status2 zero");

    xfer(8'h04, 8, 0, 1'b1, 1'b0, 1'b0, "R7 write disable");
    wel_m = 1'b0;
    check(wel == 1'b0, "R7 wel cleared", {7'b0, wel}, 8'h00);
    xfer(8'h05, 8, 1, 1'b0, 1'b1, 1'b0, "R7 status after disable");

    xfer(8'h06, 8, 0, 1'b1, 1'b0, 1'b0, "R7 write enable mode 3");
    wel_m = 1'b1;
    xfer(8'h04, 5, 0, 1'b0, 1'b0, 1'b0, "R9 short disable");
    check(wel == 1'b1, "R9 short disable ignored", {7'b0, wel}, 8'h01);

    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    wel_m = 1'b0;
    @(negedge clk);
    check(wel == 1'b0, "R8 done clears wel", {7'b0, wel}, 8'h00);
    xfer(8'h05, 8, 1, 1'b1, 1'b1, 1'b0, "R8 status after done");

    xfer(8'h06, 7, 0, 1'b0, 1'b0, 1'b0, "R9 short enable");
    check(wel == 1'b0, "R9 short enable ignored", {7'b0, wel}, 8'h00);
    xfer(8'h05, 4, 1, 1'b0, 1'b0, 1'b0, "R9 R10 short read no output");

    xfer(8'h9F, 8, 2, 1'b0, 1'b0, 1'b0, "R10 unknown opcode");
    check(wel == 1'b0, "R10 wel unchanged", {7'b0, wel}, 8'h00);
    xfer(8'h05, 8, 1, 1'b0, 1'b1, 1'b0, "R10 status after unknown");

    wait_clk(4);
    check(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule